// File: doc/BRIEF.md
# Cache-Footprint Warp Issue Throttle

This block decides, on every cycle, which warp slots may issue instructions. For each warp inside a loop it predicts how many cache lines the loop body will occupy. Each warp has one tracking entry. The prediction is built from the loads the warp executes, using their classification (divergent or converged, and an equivalence class for the cache line) together with the warp's current number of active lanes. Warps are considered oldest first, starting at slot 0. A running sum of their footprints is compared with an effective cache capacity. A warp whose share would push the running sum past that capacity is held back before it can evict the working sets of older warps.

The loop-event source, the load classifier and the issue stage sit outside this block. It sees loop entry and exit events, one load descriptor per cycle and active-lane count updates. It returns a registered issue-enable mask with one bit per warp slot. Nested loops are handled by depth: entering an inner loop starts a new prediction, and leaving it keeps whatever the inner loop predicted.

Top module: `fp_issue_throttle`

## Requirements
- R1: After reset every bit of `issue_en` is 1, every footprint is zero and every warp's active-lane count equals LANES.
- R2: A converged load (`ld_div`=0) made inside a loop adds 2 lines to its warp's footprint. This happens only for the first load of each class value `ld_class` since the warp entered the current loop. Repeats of that class add nothing.
- R3: Every divergent load (`ld_div`=1) inside a loop adds the warp's active-lane count to its footprint. Repeats of the same class are counted each time.
- R4: The footprint is always formed from the warp's current lane count, so lowering the count through `lane_vld`/`lane_cnt` reduces the share of divergent loads already counted.
- R5: Effective capacity is (CACHE_LINES*K_NUM)>>K_SHIFT, which is 24 with the default parameters. Warp i is enabled when the sum of the footprints of warps 0..i is at most that capacity. Lower slot numbers have higher priority.
- R6: A warp with a zero footprint, including any warp outside all loops, is always enabled.
- R7: Warp 0, the oldest slot, is always enabled, even if its own footprint exceeds capacity.
- R8: Entering a loop, whether outer or nested, replaces the warp's prediction with a fresh empty one. Leaving an inner loop keeps the current prediction. Leaving the outermost loop clears it to zero.
- R9: A load and a loop entry for the same warp in the same cycle: the load is counted into the fresh prediction. A load and a loop exit for a warp inside a loop in the same cycle: the exit wins and the load is dropped.
- R10: An event sampled on rising edge N changes `issue_en` on edge N+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_vld | input | 1 | A warp enters a loop this cycle |
| enter_warp | input | WID_W | Slot of the entering warp |
| exit_vld | input | 1 | A warp leaves a loop this cycle |
| exit_warp | input | WID_W | Slot of the leaving warp |
| ld_vld | input | 1 | A classified load is reported this cycle |
| ld_warp | input | WID_W | Slot that executed the load |
| ld_div | input | 1 | 1 = divergent load, 0 = converged load |
| ld_class | input | CLS_W | Equivalence class (cache line identity) of the load |
| lane_vld | input | 1 | Active-lane count update this cycle |
| lane_warp | input | WID_W | Slot whose lane count changes |
| lane_cnt | input | LANE_W | New number of active lanes |
| issue_en | output | NUM_WARPS | Registered issue-enable mask, bit i for slot i |

## Verification
Two functions can coincide in one cycle: the loop-boundary logic and the load accumulator can both act on the same warp. The bench provokes this by raising `enter_vld` together with a divergent `ld_vld` for one warp. It then adds loads until the warp's footprint reaches exactly the capacity. At that point the mask only comes out right if the coincident load was counted. In a second case the bench raises `exit_vld` on an inner loop together with a divergent load. It checks, through a younger warp that sits right on the capacity edge, that the kept prediction did not grow.

// File: rtl/fpt_pkg.sv
package fpt_pkg;

  // Per-warp loop boundary action taken in one cycle.
  typedef enum logic [1:0] {
    LOOP_HOLD = 2'd0,
    LOOP_IN   = 2'd1,
    LOOP_OUT  = 2'd2
  } loop_op_e;

  // Bits needed for one warp's largest possible footprint.
  function automatic int unsigned fp_bits(input int unsigned classes,
                                          input int unsigned lanes,
                                          input int unsigned div_max);
    return $clog2(2 * classes + lanes * div_max + 1);
  endfunction

endpackage

// File: rtl/fpt_warp_entry.sv
module fpt_warp_entry
  import fpt_pkg::*;
#(
  parameter int unsigned LANES       = 8,
  parameter int unsigned NUM_CLASSES = 8,
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned DEPTH_W     = 2,
  localparam int unsigned LANE_W = $clog2(LANES + 1),
  localparam int unsigned CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int unsigned FP_W   = fp_bits(NUM_CLASSES, LANES, (1 << DIV_W) - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_i,
  input  logic              exit_i,
  input  logic              ld_i,
  input  logic              ld_div_i,
  input  logic [CLS_W-1:0]  ld_class_i,
  input  logic              lane_i,
  input  logic [LANE_W-1:0] lane_cnt_i,
  output logic [FP_W-1:0]   fp_o
);

  localparam int unsigned CONV_W = $clog2(NUM_CLASSES + 1);
  localparam logic [DIV_W-1:0]   DIV_MAX   = '1;
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;

  logic [DEPTH_W-1:0]     depth;
  logic [CONV_W-1:0]      conv_cnt;
  logic [DIV_W-1:0]       div_cnt;
  logic [NUM_CLASSES-1:0] seen;
  logic [LANE_W-1:0]      lanes;
  logic                   in_loop;
  loop_op_e               op;

  assign in_loop = (depth != '0);

  // Exit only counts when inside a loop; it then outranks entry and loads.
  always_comb begin
    if (exit_i && in_loop)  op = LOOP_OUT;
    else if (enter_i)       op = LOOP_IN;
    else                    op = LOOP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth    <= '0;
      conv_cnt <= '0;
      div_cnt  <= '0;
      seen     <= '0;
      lanes    <= LANE_W'(LANES);
    end else begin
      if (lane_i) lanes <= lane_cnt_i;
      case (op)
        LOOP_OUT: begin
          depth <= depth - 1'b1;
          if (depth == DEPTH_W'(1)) begin
            conv_cnt <= '0;
            div_cnt  <= '0;
            seen     <= '0;
          end
        end
        LOOP_IN: begin
          if (depth != DEPTH_MAX) depth <= depth + 1'b1;
          conv_cnt <= CONV_W'(ld_i && !ld_div_i);
          div_cnt  <= DIV_W'(ld_i && ld_div_i);
          seen     <= (ld_i && !ld_div_i) ? (NUM_CLASSES'(1) << ld_class_i) : '0;
        end
        default: begin
          if (ld_i && in_loop) begin
            if (ld_div_i) begin
              if (div_cnt != DIV_MAX) div_cnt <= div_cnt + 1'b1;
            end else if (!seen[ld_class_i]) begin
              conv_cnt         <= conv_cnt + 1'b1;
              seen[ld_class_i] <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // Two lines per distinct converged class plus active lanes per divergent load.
  always_comb begin
    fp_o = FP_W'({conv_cnt, 1'b0}) + FP_W'(FP_W'(lanes) * FP_W'(div_cnt));
  end

  // R8
  outer_exit_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (exit_i && depth == DEPTH_W'(1)) |=> (conv_cnt == '0 && div_cnt == '0));

  // R8
  entry_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    (enter_i && !(exit_i && in_loop)) |=> (in_loop && conv_cnt <= CONV_W'(1) && div_cnt <= DIV_W'(1)));

  // R2
  class_counted_once_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !ld_div_i && in_loop && !enter_i && !exit_i && seen[ld_class_i]) |=> $stable(conv_cnt));

endmodule

// File: rtl/fpt_prefix_gate.sv
module fpt_prefix_gate #(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned FP_W      = 7,
  parameter int unsigned CAP_LINES = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WARPS-1:0][FP_W-1:0] fp_i,
  output logic [NUM_WARPS-1:0]           en_o
);

  localparam int unsigned SUM_W = FP_W + $clog2(NUM_WARPS + 1) + 1;

  logic [SUM_W-1:0]     run;
  logic [NUM_WARPS-1:0] en_nxt;

  // Running sum in priority order: slot 0 first.
  always_comb begin
    run = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      run       = run + SUM_W'(fp_i[i]);
      en_nxt[i] = (i == 0) || (fp_i[i] == '0) || (32'(run) <= CAP_LINES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_o <= '1;
    else     en_o <= en_nxt;
  end

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_idle
    // R6
    idle_warp_free_chk: assert property (@(posedge clk) disable iff (rst)
      (fp_i[g] == '0) |=> en_o[g]);
  end

endmodule

// File: rtl/fp_issue_throttle.sv
module fp_issue_throttle
  import fpt_pkg::*;
#(
  parameter int unsigned NUM_WARPS   = 4,
  parameter int unsigned LANES       = 8,
  parameter int unsigned NUM_CLASSES = 8,
  parameter int unsigned DIV_W       = 3,
  parameter int unsigned DEPTH_W     = 2,
  parameter int unsigned CACHE_LINES = 32,
  parameter int unsigned K_NUM       = 3,
  parameter int unsigned K_SHIFT     = 2,
  localparam int unsigned WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int unsigned CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int unsigned LANE_W = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enter_vld,
  input  logic [WID_W-1:0]     enter_warp,
  input  logic                 exit_vld,
  input  logic [WID_W-1:0]     exit_warp,
  input  logic                 ld_vld,
  input  logic [WID_W-1:0]     ld_warp,
  input  logic                 ld_div,
  input  logic [CLS_W-1:0]     ld_class,
  input  logic                 lane_vld,
  input  logic [WID_W-1:0]     lane_warp,
  input  logic [LANE_W-1:0]    lane_cnt,
  output logic [NUM_WARPS-1:0] issue_en
);

  localparam int unsigned FP_W      = fp_bits(NUM_CLASSES, LANES, (1 << DIV_W) - 1);
  localparam int unsigned CAP_LINES = (CACHE_LINES * K_NUM) >> K_SHIFT;

  logic [NUM_WARPS-1:0][FP_W-1:0] fp;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic hit_enter, hit_exit, hit_ld, hit_lane;
    assign hit_enter = enter_vld && (enter_warp == WID_W'(w));
    assign hit_exit  = exit_vld  && (exit_warp  == WID_W'(w));
    assign hit_ld    = ld_vld    && (ld_warp    == WID_W'(w));
    assign hit_lane  = lane_vld  && (lane_warp  == WID_W'(w));

    fpt_warp_entry #(
      .LANES       (LANES),
      .NUM_CLASSES (NUM_CLASSES),
      .DIV_W       (DIV_W),
      .DEPTH_W     (DEPTH_W)
    ) u_entry (
      .clk        (clk),
      .rst        (rst),
      .enter_i    (hit_enter),
      .exit_i     (hit_exit),
      .ld_i       (hit_ld),
      .ld_div_i   (ld_div),
      .ld_class_i (ld_class),
      .lane_i     (hit_lane),
      .lane_cnt_i (lane_cnt),
      .fp_o       (fp[w])
    );
  end

  fpt_prefix_gate #(
    .NUM_WARPS (NUM_WARPS),
    .FP_W      (FP_W),
    .CAP_LINES (CAP_LINES)
  ) u_gate (
    .clk  (clk),
    .rst  (rst),
    .fp_i (fp),
    .en_o (issue_en)
  );

  // R7
  oldest_warp_on_chk: assert property (@(posedge clk) disable iff (rst)
    issue_en[0]);

endmodule

// File: tb/fp_issue_throttle_bench.sv
`timescale 1ns/1ps
module fp_issue_throttle_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter_vld = 1'b0, exit_vld = 1'b0, ld_vld = 1'b0, lane_vld = 1'b0;
  logic [1:0] enter_warp = '0, exit_warp = '0, ld_warp = '0, lane_warp = '0;
  logic       ld_div = 1'b0;
  logic [2:0] ld_class = '0;
  logic [3:0] lane_cnt = '0;
  logic [3:0] issue_en;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  fp_issue_throttle u_fp_issue_throttle (
    .clk(clk), .rst(rst),
    .enter_vld(enter_vld), .enter_warp(enter_warp),
    .exit_vld(exit_vld), .exit_warp(exit_warp),
    .ld_vld(ld_vld), .ld_warp(ld_warp), .ld_div(ld_div), .ld_class(ld_class),
    .lane_vld(lane_vld), .lane_warp(lane_warp), .lane_cnt(lane_cnt),
    .issue_en(issue_en)
  );

  // Inputs are held across one rising edge, then released at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    enter_vld = 1'b0; exit_vld = 1'b0; ld_vld = 1'b0; lane_vld = 1'b0;
  endtask

  task automatic enter(input int w);
    enter_vld = 1'b1; enter_warp = 2'(w); tick();
  endtask

  task automatic leave(input int w);
    exit_vld = 1'b1; exit_warp = 2'(w); tick();
  endtask

  task automatic load(input int w, input bit div, input int cls);
    ld_vld = 1'b1; ld_warp = 2'(w); ld_div = div; ld_class = 3'(cls); tick();
  endtask

  task automatic lanes(input int w, input int n);
    lane_vld = 1'b1; lane_warp = 2'(w); lane_cnt = 4'(n); tick();
  endtask

  task automatic check_now(input logic [3:0] exp, input string req);
    vectors++;
    if (issue_en !== exp) begin
      fails++;
      $display("FAIL %s: issue_en=%b expected %b", req, issue_en, exp);
    end
  endtask

  // Let the registered mask follow the last sampled event, then compare.
  task automatic check(input logic [3:0] exp, input string req);
    @(posedge clk);
    @(negedge clk);
    check_now(exp, req);
  endtask

  task automatic t_reset();
    check(4'b1111, "R1 reset mask");
  endtask

  task automatic t_footprint();
    enter(1);
    for (int c = 0; c < 8; c++) load(1, 1'b0, c);
    check(4'b1111, "R2 eight classes give 16");
    load(1, 1'b0, 3);
    load(1, 1'b1, 3);
    check(4'b1111, "R3 R5 sum equals capacity 24");
    load(1, 1'b0, 0);
    check(4'b1111, "R2 repeated class adds nothing");
    load(1, 1'b1, 3);
    check_now(4'b1111, "R10 mask unchanged one edge after event");
    check(4'b1101, "R3 R10 repeated divergent adds 8 more");
    lanes(1, 1);
    check(4'b1111, "R4 fewer lanes shrink footprint to 18");
  endtask

  task automatic t_prefix();
    enter(2);
    for (int c = 0; c < 4; c++) load(2, 1'b0, c);
    check(4'b1011, "R5 R6 warp2 over, idle warp3 free");
    enter(3);
    load(3, 1'b0, 0);
    check(4'b0011, "R5 warp3 beyond prefix");
    leave(1);
    check(4'b1111, "R8 outer exit clears warp1");
  endtask

  task automatic t_oldest();
    enter(0);
    for (int k = 0; k < 4; k++) load(0, 1'b1, k);
    check(4'b0011, "R7 R6 oldest stays on at 32");
  endtask

  task automatic t_nested();
    enter(0);
    check(4'b1111, "R8 inner entry replaces prediction");
    load(0, 1'b1, 0);
    load(0, 1'b1, 0);
    load(0, 1'b0, 5);
    load(0, 1'b0, 6);
    check(4'b0011, "R8 inner prediction 20");
    leave(0);
    check(4'b0011, "R8 inner exit keeps prediction");
    leave(0);
    check(4'b1111, "R8 outermost exit clears");
  endtask

  task automatic t_same_cycle();
    lanes(1, 8);
    enter_vld = 1'b1; enter_warp = 2'd1;
    ld_vld = 1'b1; ld_warp = 2'd1; ld_div = 1'b1; ld_class = 3'd2;
    tick();
    check(4'b1111, "R9 entry with load, 8 lines");
    load(1, 1'b1, 2);
    load(1, 1'b1, 2);
    check(4'b0011, "R9 load beside entry was counted");
    enter(1);
    load(1, 1'b1, 4);
    check(4'b1111, "R8 R9 nested warp1 at 8");
    exit_vld = 1'b1; exit_warp = 2'd1;
    ld_vld = 1'b1; ld_warp = 2'd1; ld_div = 1'b1; ld_class = 3'd4;
    tick();
    check(4'b1111, "R9 load beside inner exit dropped");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_footprint();
    t_prefix();
    t_oldest();
    t_nested();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule